// File: doc/BRIEF.md
# Card Interface Interrupt Controller

This block raises an active-low interrupt toward a host whenever something happens at a smart card slot. The three triggers are a card arriving, a card leaving, and an overload on the card supply. The host reads a status byte and acknowledges the interrupt over a byte-wide serial command. The interrupt does not depend on chip select or on any chip address, so it can fire at any moment. Several readers can share one host line, and the host polls each reader's status to find the source.

The host acknowledges by writing the card-supply level field rather than a dedicated clear bit. A nonzero level acknowledges an insertion or an overload. A zero level acknowledges an extraction. When the card is pulled out, or the supply is overloaded, the block forces the supply field to zero by itself and pulses a power-down request for the external converter.

All pins are sampled in the system clock domain through two-flop synchronizers. Edges are found on the synchronized levels. The serial port is oversampled: the host must keep each serial clock phase for several system clocks.

Top module: `card_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_n` is 1, `vcc_sel` is 0, `pwr_dn` is 0 and `miso` is 0.
- R2: A rising or a falling edge of the synchronized `card_det` drives `irq_n` low, and it stays low until it is acknowledged.
- R3: A rising edge of the synchronized `ovl_flag` drives `irq_n` low, forces `vcc_sel` to 0 and raises `pwr_dn` for one clock. A falling edge of `ovl_flag` has no effect.
- R4: A falling edge of the synchronized `card_det` forces `vcc_sel` to 0 and raises `pwr_dn` for exactly one clock.
- R5: Interrupt assertion does not depend on `cs_n` or on any received address. It happens while `cs_n` is high.
- R6: A command byte is received MSB first on `sclk` rising edges while `cs_n` is low. It is committed on the rising edge of `cs_n`. It is accepted only if at least 8 bits were received and its bits [7:5] are 0xx or 101. Fewer bits, or any other address, leave all state unchanged.
- R7: An accepted command loads its bits [1:0] into `vcc_sel` and returns `irq_n` to 1, whether the value is zero or not.
- R8: If a card or overload event and an accepted command fall in the same clock, the event wins. `irq_n` stays low, and a forced supply shutdown overrides the written value.
- R9: If a card is pulled out and put back (or the reverse) before an acknowledge, `irq_n` stays low in every clock, with no pulse high.
- R10: While `cs_n` is high, toggling `sclk` and `mosi` changes neither `vcc_sel` nor `irq_n`.
- R11: During a transfer, `miso` returns a status byte MSB first. Bit 7 is card present, bit 6 is overload, bit 5 is interrupt pending, and bits 4:0 are 0. Bit 7 is presented after `cs_n` falls, and each further bit after each `sclk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_det | input | 1 | Card present level, asynchronous |
| ovl_flag | input | 1 | Card supply overload flag, asynchronous |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock (oversampled) |
| mosi | input | 1 | Serial command data, MSB first |
| irq_n | output | 1 | Interrupt level, active low, registered |
| vcc_sel | output | 2 | Card supply level field, 0 means off |
| pwr_dn | output | 1 | One-clock power-down request |
| miso | output | 1 | Serial status readback |

## Verification
The bench places an extraction in the same clock as the `cs_n` rising edge that commits a valid acknowledge. A design that favours the acknowledge would release `irq_n` and keep the written supply value. It pulls out and reinserts a card while watching `irq_n` in every clock, which exposes a design that re-arms on each edge with a brief high pulse. Commands with rejected address patterns (100, 110, 111) and a transfer cut short at five bits must leave both the supply and the interrupt untouched. A decoder that looks only at bit 7, or one that commits without a full byte, would change them. The status readback is checked both with and without a pending interrupt, which catches swapped or stale status bits.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int BYTE_W  = 8;
  localparam int VCC_W   = 2;
  localparam int SYNC_N  = 2;

  typedef struct packed {
    logic       present;
    logic       overload;
    logic       pending;
    logic [4:0] zero;
  } status_t;

  // Address field is the top three bits: 0xx or 101 selects this chip.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1] == 1'b0) || (b[BYTE_W-1 -: 3] == 3'b101);
  endfunction
endpackage

// File: rtl/card_irq_sync.sv
module card_irq_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)         chain[g] <= RST_V;
        else if (g == 0) chain[g] <= d;
        else             chain[g] <= chain[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/card_irq_serial.sv
module card_irq_serial
  import card_irq_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic [BW-1:0] status,
  output logic          cmd_vld,
  output logic [BW-1:0] cmd,
  output logic          miso
);
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BW);

  logic            cs_q, sclk_q;
  logic [BW-1:0]   rx_sh, tx_sh;
  logic [CNT_W-1:0] nbits;
  logic            cs_fall, cs_rise, sck_rise;

  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign sck_rise = sclk_s & ~sclk_q & ~cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      nbits  <= '0;
      miso   <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      if (cs_fall) begin
        tx_sh <= status;
        rx_sh <= '0;
        nbits <= '0;
      end else if (sck_rise) begin
        rx_sh <= {rx_sh[BW-2:0], mosi_s};
        tx_sh <= {tx_sh[BW-2:0], 1'b0};
        if (nbits != FULL) nbits <= nbits + 1'b1;
      end
      miso <= tx_sh[BW-1];
    end
  end

  assign cmd     = rx_sh;
  assign cmd_vld = cs_rise && (nbits == FULL) && addr_hit(rx_sh);

  // R10: with select held high across two samples, nothing is committed
  a_r10_idle_no_cmd: assert property (@(posedge clk) disable iff (rst)
    (cs_s && cs_q) |-> !cmd_vld);
  // R6: a committed command always carries a selecting address
  a_r6_addr_ok: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> (!cmd[BW-1] || cmd[BW-1 -: 3] == 3'b101));
endmodule

// File: rtl/card_irq_core.sv
module card_irq_core
  import card_irq_pkg::*;
#(
  parameter int VW = VCC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          det_s,
  input  logic          ovl_s,
  input  logic          ack,
  input  logic [VW-1:0] wr_val,
  output logic          irq_n,
  output logic [VW-1:0] vcc_sel,
  output logic          pwr_dn,
  output logic          pending
);
  logic det_q, ovl_q;
  logic ins_ev, ext_ev, ovl_ev, fault, any_ev, pend_nx;

  assign ins_ev  = det_s & ~det_q;
  assign ext_ev  = ~det_s & det_q;
  assign ovl_ev  = ovl_s & ~ovl_q;
  assign fault   = ext_ev | ovl_ev;
  assign any_ev  = ins_ev | fault;
  assign pend_nx = any_ev ? 1'b1 : (ack ? 1'b0 : pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q   <= 1'b0;
      ovl_q   <= 1'b0;
      pending <= 1'b0;
      irq_n   <= 1'b1;
      vcc_sel <= '0;
      pwr_dn  <= 1'b0;
    end else begin
      det_q   <= det_s;
      ovl_q   <= ovl_s;
      pending <= pend_nx;
      irq_n   <= ~pend_nx;
      pwr_dn  <= fault;
      if (fault)    vcc_sel <= '0;
      else if (ack) vcc_sel <= wr_val;
    end
  end

  a_r2_card_edge_irq: assert property (@(posedge clk) disable iff (rst)
    (ins_ev || ext_ev) |=> !irq_n);
  a_r3_overload_off: assert property (@(posedge clk) disable iff (rst)
    ovl_ev |=> (!irq_n && vcc_sel == '0 && pwr_dn));
  a_r4_extract_off: assert property (@(posedge clk) disable iff (rst)
    ext_ev |=> (vcc_sel == '0 && pwr_dn));
  a_r7_ack_release: assert property (@(posedge clk) disable iff (rst)
    (ack && !any_ev) |=> (irq_n && vcc_sel == $past(wr_val)));
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (ack && any_ev) |=> !irq_n);
  a_r9_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !ack) |=> !irq_n);
  a_r7_supply_stable: assert property (@(posedge clk) disable iff (rst)
    (!ack && !fault) |=> $stable(vcc_sel));
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             card_det,
  input  logic             ovl_flag,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  output logic             irq_n,
  output logic [VCC_W-1:0] vcc_sel,
  output logic             pwr_dn,
  output logic             miso
);
  logic [1:0]        card_s;
  logic [2:0]        host_s;
  logic              ack, pending;
  logic [BYTE_W-1:0] cmd;
  status_t           stat;

  card_irq_sync #(.W(2), .STAGES(SYNC_N), .RST_V(2'b00)) u_card_sync (
    .clk(clk), .rst(rst), .d({card_det, ovl_flag}), .q(card_s));

  card_irq_sync #(.W(3), .STAGES(SYNC_N), .RST_V(3'b100)) u_host_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, mosi}), .q(host_s));

  assign stat = '{present: card_s[1], overload: card_s[0],
                  pending: pending, zero: 5'd0};

  card_irq_serial #(.BW(BYTE_W)) u_serial (
    .clk(clk), .rst(rst), .cs_s(host_s[2]), .sclk_s(host_s[1]),
    .mosi_s(host_s[0]), .status(stat), .cmd_vld(ack), .cmd(cmd),
    .miso(miso));

  card_irq_core #(.VW(VCC_W)) u_core (
    .clk(clk), .rst(rst), .det_s(card_s[1]), .ovl_s(card_s[0]),
    .ack(ack), .wr_val(cmd[VCC_W-1:0]), .irq_n(irq_n),
    .vcc_sel(vcc_sel), .pwr_dn(pwr_dn), .pending(pending));
endmodule

// File: tb/card_irq_ctrl_test.sv
`timescale 1ns/1ps
module card_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic card_det = 1'b0, ovl_flag = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic irq_n, pwr_dn, miso;
  logic [1:0] vcc_sel;
  int n_chk = 0, n_bad = 0;
  logic mon_en = 1'b0;
  int   hi_cnt = 0, pd_cnt = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  card_irq_ctrl uut (
    .clk(clk), .rst(rst), .card_det(card_det), .ovl_flag(ovl_flag),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .irq_n(irq_n),
    .vcc_sel(vcc_sel), .pwr_dn(pwr_dn), .miso(miso));

  always @(negedge clk) if (mon_en) begin
    if (irq_n)  hi_cnt++;
    if (pwr_dn) pd_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nbits, input bit raise,
                      output logic [7:0] got);
    got = 8'h00;
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7-i];
      repeat (6) @(negedge clk);
      got[7-i] = miso;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    if (raise) begin
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  // {det, ovl, send, byte[7:0], exp_irq_n, exp_vcc[1:0]}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0},  // R2 R5 insertion, select high
    {1'b1, 1'b0, 1'b1, 8'h03, 1'b1, 2'd3},  // R6 R7 address 000 accepted
    {1'b1, 1'b0, 1'b1, 8'hC1, 1'b1, 2'd3},  // R6 address 110 rejected
    {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0},  // R3 overload rise
    {1'b1, 1'b1, 1'b1, 8'hA2, 1'b1, 2'd2},  // R6 R7 address 101 accepted
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2},  // R3 overload fall ignored
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0},  // R2 R4 extraction
    {1'b0, 1'b0, 1'b1, 8'hE0, 1'b0, 2'd0},  // R6 address 111 rejected
    {1'b0, 1'b0, 1'b1, 8'h40, 1'b1, 2'd0},  // R7 zero write acks extraction
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0},  // R2 insertion
    {1'b1, 1'b0, 1'b1, 8'h81, 1'b0, 2'd0},  // R6 address 100 rejected
    {1'b1, 1'b0, 1'b1, 8'h61, 1'b1, 2'd1}   // R6 R7 address 011 accepted
  };

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 vcc_sel", int'(vcc_sel), 0);
    chk("R1 pwr_dn", int'(pwr_dn), 0);
    chk("R1 miso", int'(miso), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      card_det = VEC[v][13];
      ovl_flag = VEC[v][12];
      repeat (8) @(negedge clk);
      if (VEC[v][11]) xfer(VEC[v][10:3], 8, 1'b1, rd);
      chk($sformatf("R2-R7 vector %0d irq_n", v), int'(irq_n), int'(VEC[v][2]));
      chk($sformatf("R2-R7 vector %0d vcc_sel", v), int'(vcc_sel), int'(VEC[v][1:0]));
    end

    // R10: serial clock and data toggling with select high
    for (int i = 0; i < 16; i++) begin
      mosi = i[0];
      sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    chk("R10 vcc_sel unchanged", int'(vcc_sel), 1);
    chk("R10 irq_n unchanged", int'(irq_n), 1);

    // R6: short transfer (5 bits of a valid write) is dropped
    xfer(8'h03, 5, 1'b1, rd);
    chk("R6 short transfer vcc_sel", int'(vcc_sel), 1);

    // R11: status readback, no pending interrupt, card present
    xfer(8'hE0, 8, 1'b1, rd);
    chk("R11 status idle", int'(rd), 8'h80);

    // R11: status with overload and pending interrupt; rejected command keeps irq
    ovl_flag = 1'b1;
    repeat (8) @(negedge clk);
    xfer(8'hE0, 8, 1'b1, rd);
    chk("R11 status pending", int'(rd), 8'hE0);
    chk("R3 irq held after rejected cmd", int'(irq_n), 0);
    ovl_flag = 1'b0;
    repeat (8) @(negedge clk);
    xfer(8'h03, 8, 1'b1, rd);
    chk("R7 ack after overload", int'(irq_n), 1);

    // R8: extraction in the same clock as a valid acknowledge commit
    xfer(8'h02, 8, 1'b0, rd);
    cs_n = 1'b1;
    card_det = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 irq_n stays low", int'(irq_n), 0);
    chk("R8 supply forced off", int'(vcc_sel), 0);

    // R9 + R4: reinsert, extract, reinsert with interrupt still pending
    hi_cnt = 0; pd_cnt = 0; mon_en = 1'b1;
    card_det = 1'b1; repeat (8) @(negedge clk);
    card_det = 1'b0; repeat (8) @(negedge clk);
    card_det = 1'b1; repeat (8) @(negedge clk);
    mon_en = 1'b0;
    chk("R9 no high pulse on irq_n", hi_cnt, 0);
    chk("R4 single power-down pulse", pd_cnt, 1);
    xfer(8'h01, 8, 1'b1, rd);
    chk("R7 final ack irq_n", int'(irq_n), 1);
    chk("R7 final ack vcc_sel", int'(vcc_sel), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule